// File: doc/BRIEF.md
# Conditional-Sum Binary Adder

A purely combinational adder for two wide unsigned operands plus a carry-in. It returns the full-width sum and the carry-out. The operand is split in half. The low half is added with the real carry-in. At the same time, the high half is added twice: once assuming no carry arrives from below, and once assuming one does. The carry-out of the low half then picks one of the two high results and its matching carry.

The same split is applied again inside every half until the pieces reach a small base width. At that width a plain ripple-carry adder does the work. Only one selection stage is added per level of splitting. The critical path therefore grows with the logarithm of the width instead of with the width itself.

The block is meant as a datapath library element. The width and the base width are parameters. The width must be the base width times a power of two, and any other value is rejected when the design is elaborated.

Top module: `cond_sum_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals the 65-bit (WIDTH+1) unsigned sum `op_a + op_b + carry_in` for any operands.
- R2: Raising `carry_in` from 0 to 1 with the same operands increases the `{carry_o, sum_o}` value by exactly one.
- R3: At every split, the high-half result computed with an assumed carry of 1 equals the result computed with an assumed carry of 0, plus one, modulo the half width.
- R4: At every split, if the high half carries out with an assumed carry of 0, it also carries out with an assumed carry of 1.
- R5: A carry produced at any piece boundary, meaning any bit position that is a multiple of BASE_W (4 by default), reaches the upper bits correctly. This holds both for a carry that ends just above the boundary and for one that ripples through a run of ones up to the top bit.
- R6: Each base piece of BASE_W bits produces exactly the ripple-carry sum of its own inputs. For operands that fit in the lowest piece, the result equals their plain sum.
- R7: All-ones `op_a` with `op_b` = 0 and `carry_in` = 1 gives `sum_o` = 0 and `carry_o` = 1. The same holds for any pair with `op_b` equal to the bitwise inverse of `op_a`.
- R8: With `op_b` = 0 and `carry_in` = 0, `sum_o` equals `op_a` and `carry_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry added at bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The most telling stimulus is a carry that starts at a piece or half boundary. Sweeping a run of ones ending at every multiple of the base width, and a run reaching the top bit, catches a select line wired to the wrong carry. It also catches swapped high-half variants, which would make the sum off by one exactly above the boundary. A carry-out taken from the wrong variant shows up only when the top half is all ones, so the all-ones plus carry-in and inverse-pair cases are driven explicitly. Small operands and the zero operand show errors confined to the base ripple or to the carry-in path, which random wide operands rarely isolate.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
   // True when width equals base times a power of two (base >= 1).
   function automatic bit width_ok(input int unsigned width, input int unsigned base);
      int unsigned w;
      w = width;
      if (base == 0) return 1'b0;
      while ((w > base) && (w % 2 == 0)) w = w / 2;
      return (w == base);
   endfunction
endpackage

// File: rtl/csa_ripple.sv
`timescale 1ns/1ps
module csa_ripple #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0]   chain;
   logic [W-1:0] sum_r;

   always_comb begin
      chain[0] = cin;
      for (int i = 0; i < W; i++) begin
         sum_r[i]     = a[i] ^ b[i] ^ chain[i];
         chain[i+1]   = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
      end
   end

   assign sum  = sum_r;
   assign cout = chain[W];

   // R6: bit-level chain agrees with an arithmetic add of the piece
   always_comb begin
      p_ripple_exact_r6: assert final ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
         else $error("R6 ripple piece mismatch");
   end
endmodule

// File: rtl/csa_select.sv
`timescale 1ns/1ps
module csa_select #(
   parameter int unsigned W = 4
) (
   input  logic         pick_one,
   input  logic [W-1:0] s_if0,
   input  logic         c_if0,
   input  logic [W-1:0] s_if1,
   input  logic         c_if1,
   output logic [W-1:0] s_out,
   output logic         c_out
);
   assign s_out = pick_one ? s_if1 : s_if0;
   assign c_out = pick_one ? c_if1 : c_if0;
endmodule

// File: rtl/csa_node.sv
`timescale 1ns/1ps
module csa_node #(
   parameter int unsigned W = 64,
   parameter int unsigned B = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (W <= B) begin : g_leaf
         csa_ripple #(.W(W)) u_rip (
            .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
         );
      end else begin : g_split
         localparam int unsigned H = W / 2;

         logic [H-1:0] lo_s, hi_s0, hi_s1, hi_s;
         logic         lo_c, hi_c0, hi_c1;

         csa_node #(.W(H), .B(B)) u_lo (
            .a(a[H-1:0]), .b(b[H-1:0]), .cin(cin), .sum(lo_s), .cout(lo_c)
         );
         csa_node #(.W(H), .B(B)) u_hi0 (
            .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b0), .sum(hi_s0), .cout(hi_c0)
         );
         csa_node #(.W(H), .B(B)) u_hi1 (
            .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b1), .sum(hi_s1), .cout(hi_c1)
         );
         csa_select #(.W(H)) u_sel (
            .pick_one(lo_c),
            .s_if0(hi_s0), .c_if0(hi_c0),
            .s_if1(hi_s1), .c_if1(hi_c1),
            .s_out(hi_s), .c_out(cout)
         );

         assign sum = {hi_s, lo_s};

         always_comb begin
            // R3: the two speculative high results differ by exactly one
            p_hi_gap_r3: assert final (hi_s1 == hi_s0 + H'(1))
               else $error("R3 speculative high sums not adjacent");
            // R4: carry with assumed 0 implies carry with assumed 1
            p_carry_order_r4: assert final (!hi_c0 || hi_c1)
               else $error("R4 speculative carries out of order");
         end
      end
   endgenerate
endmodule

// File: rtl/cond_sum_adder.sv
`timescale 1ns/1ps
module cond_sum_adder #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned BASE_W = 4
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o
);
   localparam bit SHAPE_OK = csa_pkg::width_ok(WIDTH, BASE_W);

   generate
      if (!SHAPE_OK) begin : g_bad_shape
         $error("WIDTH must be BASE_W times a power of two");
      end
   endgenerate

   csa_node #(.W(WIDTH), .B(BASE_W)) u_root (
      .a(op_a), .b(op_b), .cin(carry_in), .sum(sum_o), .cout(carry_o)
   );

   always_comb begin
      // R7: inverse pair plus carry wraps to zero with carry out
      p_wrap_r7: assert final (!((op_b == ~op_a) && carry_in) || ((sum_o == '0) && carry_o))
         else $error("R7 wrap case wrong");
      // R8: adding zero passes the operand through
      p_identity_r8: assert final (!((op_b == '0) && !carry_in) || ((sum_o == op_a) && !carry_o))
         else $error("R8 identity case wrong");
   end
endmodule

// File: tb/cond_sum_adder_bench.sv
`timescale 1ns/1ps
module cond_sum_adder_bench;
   localparam int unsigned WIDTH  = 64;
   localparam int unsigned BASE_W = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [WIDTH-1:0] op_a = '0, op_b = '0;
   logic             carry_in = 1'b0;
   logic [WIDTH-1:0] sum_o;
   logic             carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cond_sum_adder #(.WIDTH(WIDTH), .BASE_W(BASE_W)) u_cond_sum_adder (
      .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sum_o(sum_o), .carry_o(carry_o)
   );

   // Behavioural reference: one wide integer add, queued per applied vector
   logic [WIDTH:0] exp_q[$];
   string          tag_q[$];

   task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                        input logic ci, input string tag);
      @(posedge clk); #1;
      op_a = a; op_b = b; carry_in = ci;
      exp_q.push_back({1'b0, a} + {1'b0, b} + (WIDTH+1)'(ci));
      tag_q.push_back(tag);
      @(negedge clk);
      check_out();
   endtask

   task automatic check_out();
      logic [WIDTH:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if ({carry_o, sum_o} !== e) begin
         n_fail++;
         $display("FAIL %s: got carry=%b sum=%h expected carry=%b sum=%h",
                  t, carry_o, sum_o, e[WIDTH], e[WIDTH-1:0]);
      end
   endtask

   function automatic logic [WIDTH-1:0] rnd();
      return {$urandom(), $urandom()};
   endfunction

   always @(posedge clk) cycles <= cycles + 1;

   initial begin
      wait (cycles > 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [WIDTH-1:0] ones;
      logic [WIDTH-1:0] x;
      ones = '1;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Reset-state inputs: zero plus zero
      apply('0, '0, 1'b0, "R8 zero inputs");

      // R8 identity
      apply(64'h0123_4567_89AB_CDEF, '0, 1'b0, "R8 pass-through");
      apply(ones, '0, 1'b0, "R8 all ones pass-through");

      // R7 wrap
      apply(ones, '0, 1'b1, "R7 all ones plus carry");
      apply(64'hDEAD_BEEF_0000_FFFF, ~64'hDEAD_BEEF_0000_FFFF, 1'b1, "R7 inverse pair");
      apply(ones, ones, 1'b1, "R1 max operands");

      // R6 small operands in the lowest piece
      for (int i = 0; i < 16; i++) begin
         apply(WIDTH'(i), WIDTH'(15 - i), 1'b1, "R6 base piece");
         apply(WIDTH'(i), WIDTH'(i), 1'b0, "R6 base piece doubled");
      end

      // R5 / R3 / R4 carry born at every piece boundary
      for (int k = BASE_W; k < WIDTH; k += BASE_W) begin
         x = (WIDTH'(1) << k) - WIDTH'(1);
         apply(x, WIDTH'(1), 1'b0, "R5 boundary carry stops above");
         apply(x, '0, 1'b1, "R3 boundary carry from carry_in");
         apply(ones << k, x, 1'b1, "R4 carry ripples to top");
         apply(ones ^ (WIDTH'(1) << k), WIDTH'(1) << (k - 1), 1'b0, "R5 single carry into boundary");
      end

      // R2 carry_in increments the result
      for (int i = 0; i < 40; i++) begin
         x = rnd();
         apply(x, ~x, 1'b0, "R2 inverse pair no carry");
         apply(rnd(), rnd(), 1'b1, "R2 random with carry_in");
      end

      // R1 random operands
      for (int i = 0; i < 3000; i++) begin
         apply(rnd(), rnd(), 1'($urandom()), "R1 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule